// File: doc/BRIEF.md
# ATA Drive Presence Probe

This block sits on the host side of a parallel ATA port. It answers one question after a start pulse: is a drive attached? It uses a simple register access port to reach the drive's registers. It polls the status register until the busy bit drops, and it counts timekeeping ticks so that it gives up after a long, configurable wait. Once busy is clear, it writes two complementary patterns to the sector count register and reads each one back. Only a register set that keeps what was written counts as a drive.

A bus with nothing attached reads as all ones, which looks like "busy" and would stall the probe until the timeout. With the top data bit pulled low, an empty bus reads 7Fh instead. The probe then sees busy clear, moves straight to the readback test, fails it, and reports an absent drive within a few dozen clock cycles instead of tens of seconds. The result is a one-cycle done pulse together with exactly one of three held flags.

Top module: `ata_presence_probe`

## Requirements
- R1: During and right after reset, reg_req, done, present, absent and timed_out are all low.
- R2: After an accepted start, the first register access is a read of offset 7 (status). Status is read again and again while its bit 7 is 1.
- R3: A status value with bit 7 clear, including a floating 7Fh, ends the busy wait at once, without waiting for ticks. An empty bus reading 7Fh is reported as absent within 40 clock cycles of start.
- R4: Once busy is clear, the probe writes 55h to offset 2, reads offset 2, then writes AAh to offset 2 and reads it again. If both reads match exactly, it reports present. Offset 2 is the only register it writes.
- R5: If the 55h readback mismatches, the probe reports absent with no further write. If the AAh readback mismatches, it also reports absent.
- R6: If status still shows busy once TICKS_PER_SEC*TIMEOUT_SEC ticks have arrived since start, the next busy status read reports timed_out. No register is written in that case.
- R7: done is a single-cycle pulse, and it comes with exactly one of present/absent/timed_out set. The flags hold until the next accepted start clears them.
- R8: A start pulse while a probe is running is ignored, so that probe produces a single done.
- R9: Each request holds reg_req, reg_we, reg_addr and reg_wdata steady until reg_done is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a probe (ignored while busy) |
| reg_req | output | 1 | Register access request, held until reg_done |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 3 | Register offset within the command block |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data, valid with reg_done |
| reg_done | input | 1 | Access complete, one cycle |
| tick | input | 1 | Timekeeping tick, one cycle wide |
| done | output | 1 | Probe finished, one-cycle pulse |
| present | output | 1 | Drive found |
| absent | output | 1 | No working register set |
| timed_out | output | 1 | Busy never cleared |

## Verification
The bench builds the block with TICKS_PER_SEC=8 and TIMEOUT_SEC=4, so the timeout falls at 32 ticks. With a tick every fourth clock, that is about 130 cycles. This brings the full timeout path, and a drive that clears busy just short of the limit, within a short run. It also keeps the 7Fh fast path clearly separate from the timeout in cycle counts. The drive model can stay busy for a chosen number of ticks, float at FFh or 7Fh, or corrupt one bit of the sector count register, so that each readback pattern fails on its own.

// File: rtl/ata_presence_probe.sv
module ata_presence_probe #(
  parameter int TICKS_PER_SEC = 1000,
  parameter int TIMEOUT_SEC   = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       reg_req,
  output logic       reg_we,
  output logic [2:0] reg_addr,
  output logic [7:0] reg_wdata,
  input  logic [7:0] reg_rdata,
  input  logic       reg_done,
  input  logic       tick,
  output logic       done,
  output logic       present,
  output logic       absent,
  output logic       timed_out
);
  localparam int LIMIT = TICKS_PER_SEC * TIMEOUT_SEC;
  localparam int TW    = $clog2(LIMIT + 1);
  localparam logic [2:0] OFS_STATUS = 3'd7;
  localparam logic [2:0] OFS_SECCNT = 3'd2;
  localparam logic [7:0] PAT_A = 8'h55;
  localparam logic [7:0] PAT_B = 8'hAA;

  typedef enum logic [2:0] {S_IDLE, S_POLL, S_WR_A, S_RD_A, S_WR_B, S_RD_B} st_t;

  st_t           st;
  logic [TW-1:0] tcnt;
  logic          expired;

  assign expired   = (tcnt == TW'(LIMIT));
  assign reg_req   = (st != S_IDLE);
  assign reg_we    = (st == S_WR_A) || (st == S_WR_B);
  assign reg_addr  = (st == S_POLL) ? OFS_STATUS : OFS_SECCNT;
  assign reg_wdata = (st == S_WR_B) ? PAT_B : PAT_A;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tcnt      <= '0;
      done      <= 1'b0;
      present   <= 1'b0;
      absent    <= 1'b0;
      timed_out <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == S_POLL && tick && !expired) tcnt <= tcnt + 1'b1;
      case (st)
        S_IDLE: if (start) begin
          st        <= S_POLL;
          tcnt      <= '0;
          present   <= 1'b0;
          absent    <= 1'b0;
          timed_out <= 1'b0;
        end
        S_POLL: if (reg_done) begin
          if (!reg_rdata[7]) st <= S_WR_A;
          else if (expired) begin
            st        <= S_IDLE;
            done      <= 1'b1;
            timed_out <= 1'b1;
          end
        end
        S_WR_A: if (reg_done) st <= S_RD_A;
        S_RD_A: if (reg_done) begin
          if (reg_rdata == PAT_A) st <= S_WR_B;
          else begin
            st     <= S_IDLE;
            done   <= 1'b1;
            absent <= 1'b1;
          end
        end
        S_WR_B: if (reg_done) st <= S_RD_B;
        S_RD_B: if (reg_done) begin
          st      <= S_IDLE;
          done    <= 1'b1;
          present <= (reg_rdata == PAT_B);
          absent  <= (reg_rdata != PAT_B);
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ata_presence_probe_chk.sv
module ata_presence_probe_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       reg_req,
  input logic       reg_we,
  input logic [2:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       reg_done,
  input logic       tick,
  input logic       done,
  input logic       present,
  input logic       absent,
  input logic       timed_out
);
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_one_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones({present, absent, timed_out}) == 1);

  assert_flags_onehot0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({present, absent, timed_out}));

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_done) |=> reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata));

  assert_write_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we) |-> reg_addr == 3'd2);

  assert_no_result_while_running_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |-> !present && !absent && !timed_out);
endmodule

bind ata_presence_probe ata_presence_probe_chk u_chk (.*);

// File: tb/sim_ata_presence_probe.sv
module sim_ata_presence_probe;
  localparam int TPS = 8;
  localparam int TSEC = 4;
  localparam int LIMIT = TPS * TSEC;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, tick = 1'b0;
  logic reg_req, reg_we, reg_done;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic done, present, absent, timed_out;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int mode = 0, busy_until = 0, tick_total = 0, div = 0, acc_cnt = 0, done_cnt = 0;
  logic lat;
  logic [7:0] sc;
  logic [2:0] log_addr [256];
  logic       log_we   [256];
  logic [7:0] log_data [256];

  ata_presence_probe #(.TICKS_PER_SEC(TPS), .TIMEOUT_SEC(TSEC)) u0 (
    .clk, .rst_n, .start, .reg_req, .reg_we, .reg_addr, .reg_wdata,
    .reg_rdata, .reg_done, .tick, .done, .present, .absent, .timed_out);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    div <= (div == 3) ? 0 : div + 1;
    tick <= (div == 3);
    if (tick) tick_total <= tick_total + 1;
    if (done) done_cnt <= done_cnt + 1;
  end

  function automatic logic [7:0] rd_val(input logic [2:0] a);
    if (mode == 1) return 8'hFF;
    if (mode == 2) return 8'h7F;
    if (a == 3'd7) return (tick_total < busy_until) ? 8'hD0 : 8'h50;
    if (a == 3'd2) return (mode == 3) ? (sc ^ 8'h01) : (mode == 4) ? (sc & 8'hFD) : sc;
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      reg_done <= 1'b0; lat <= 1'b0; reg_rdata <= 8'h00; sc <= 8'h00;
    end else begin
      reg_done <= 1'b0;
      if (reg_req && !reg_done) begin
        if (lat) begin
          lat <= 1'b0;
          reg_done <= 1'b1;
          log_addr[acc_cnt[7:0]] <= reg_addr;
          log_we[acc_cnt[7:0]] <= reg_we;
          log_data[acc_cnt[7:0]] <= reg_wdata;
          acc_cnt <= acc_cnt + 1;
          if (reg_we) begin
            if (reg_addr == 3'd2) sc <= reg_wdata;
          end else reg_rdata <= rd_val(reg_addr);
        end else lat <= 1'b1;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  int r_cycles, r_ticks, r_a0, r_acc, r_done0;

  task automatic run_probe(input int m, input int busy, input bit restart);
    int c = 0;
    @(negedge clk);
    mode = m;
    busy_until = tick_total + busy;
    r_a0 = acc_cnt; r_ticks = tick_total; r_done0 = done_cnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R7 flags cleared by start", {present, absent, timed_out}, 0);
    while (!done && c < 3000) begin
      if (restart && c == 20) start = 1'b1; else start = 1'b0;
      @(negedge clk);
      c++;
    end
    start = 1'b0;
    r_cycles = c;
    r_ticks = tick_total - r_ticks;
    r_acc = acc_cnt - r_a0;
    @(negedge clk);
    check("R7 done one cycle", done, 0);
  endtask

  function automatic int n_writes();
    int w = 0;
    for (int i = 0; i < r_acc; i++) if (log_we[(r_a0 + i) % 256]) w++;
    return w;
  endfunction

  task automatic t_reset();
    check("R1 reg_req", reg_req, 0);
    check("R1 done", done, 0);
    check("R1 flags", {present, absent, timed_out}, 0);
  endtask

  task automatic t_float_7f();
    run_probe(2, 0, 0);
    check("R3 result absent", {present, absent, timed_out}, 3'b010);
    check("R3 fast", r_cycles < 40, 1);
    check("R2 first access status read", {log_we[r_a0 % 256], log_addr[r_a0 % 256]}, {1'b0, 3'd7});
  endtask

  task automatic t_present_busy();
    int i0;
    run_probe(0, 10, 1);
    i0 = r_a0 % 256;
    check("R4 result present", {present, absent, timed_out}, 3'b100);
    check("R2 waited for busy", r_ticks >= 10, 1);
    check("R2 first access status read", {log_we[i0], log_addr[i0]}, {1'b0, 3'd7});
    check("R4 write count", n_writes(), 2);
    check("R4 access order", {log_we[(r_a0+r_acc-4)%256], log_addr[(r_a0+r_acc-4)%256], log_data[(r_a0+r_acc-4)%256]}, {1'b1, 3'd2, 8'h55});
    check("R4 readback A", {log_we[(r_a0+r_acc-3)%256], log_addr[(r_a0+r_acc-3)%256]}, {1'b0, 3'd2});
    check("R4 write B", {log_we[(r_a0+r_acc-2)%256], log_addr[(r_a0+r_acc-2)%256], log_data[(r_a0+r_acc-2)%256]}, {1'b1, 3'd2, 8'hAA});
    check("R8 single done", done_cnt - r_done0, 1);
    repeat (6) @(negedge clk);
    check("R7 flags held", {present, absent, timed_out}, 3'b100);
    check("R8 no new probe", reg_req, 0);
  endtask

  task automatic t_timeout(input int m, input int busy);
    run_probe(m, busy, 0);
    check("R6 result timed_out", {present, absent, timed_out}, 3'b001);
    check("R6 ticks at limit", (r_ticks >= LIMIT) && (r_ticks <= LIMIT + 1), 1);
    check("R6 no writes", n_writes(), 0);
  endtask

  task automatic t_near_limit();
    run_probe(0, LIMIT - 4, 0);
    check("R2 present near limit", {present, absent, timed_out}, 3'b100);
  endtask

  task automatic t_bad_a();
    run_probe(3, 0, 0);
    check("R5 absent on 55h mismatch", {present, absent, timed_out}, 3'b010);
    check("R5 stops after one write", n_writes(), 1);
  endtask

  task automatic t_bad_b();
    run_probe(4, 0, 0);
    check("R5 absent on AAh mismatch", {present, absent, timed_out}, 3'b010);
    check("R5 both writes done", n_writes(), 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_float_7f();
    t_present_busy();
    t_timeout(1, 0);
    t_timeout(0, 100000);
    t_near_limit();
    t_bad_a();
    t_bad_b();
    finish_run();
  end
endmodule